// File: doc/BRIEF.md
# ACPI Power Management Timer Unit

This block holds the power-management registers of a system controller. It has a free-running up-counter that advances once for each pulse of a tick enable. The tick stands in for a 3,579,545 Hz timebase. The block also has a status register and an enable register that share bit positions. A level-sensitive system control interrupt (SCI) is high whenever an enabled status event is pending. A control register holds the SCI mode bit and the requested sleep type, and accepts a sleep strobe that is never stored.

Software reaches the registers over a simple register bus. Reads are combinational and 32 bits wide, and the 16-bit registers are zero-extended. Writes carry 16 bits. Two events set status bits:
- A change in the counter's top bit.
- A power-button pulse, counted only when its enable bit is set.

A separate byte-wide command port switches the SCI mode on and off. It also raises a one-cycle SMI request when a configuration input allows it.

Top module: `pm_timer_unit`

## Requirements
- R1: Offset 0x08 reads the counter in the low TMR_W bits with all upper bits zero. The counter is zero after reset, and it advances by one (wrapping) on every clock where `tick` is high.
- R2: The counter holds its value while `tick` is low. A bus write to offset 0x08 does not change it.
- R3: Status bit 0 is set on the clock where the counter's top bit changes, whether it goes from 0 to 1 or from 1 to 0.
- R4: The status register is read at offset 0x00. The enable register is a 16-bit read/write register at offset 0x02. The event bits are: timer 0, global 5, power button 8, RTC 10.
- R5: A `pwr_btn` pulse sets status bit 8 only if enable bit 8 is set.
- R6: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle as the clear wins.
- R7: `sci` is high exactly when (status AND enable) has bit 10, 8, 5 or 0 set. It follows register updates in the cycle after the write or event.
- R8: The control register at offset 0x04 stores the bits written, except bit 13, which always reads 0. Bit 0 is the SCI mode bit and bits 12:10 are the sleep type.
- R9: `poff_req` pulses for one cycle after a control write that has bit 13 set and sleep type 0. Any other control write gives no pulse.
- R10: A write of 0xF1 to command port 0 (`cmd_sel`=0) sets control bit 0, and a write of 0xF0 clears it. Other values leave control bit 0 unchanged. The last value written reads back on `cmd_rdata`, and the command port wins over a bus write to control in the same cycle.
- R11: Command port 1 (`cmd_sel`=1) is a plain byte of storage. It is independent of port 0.
- R12: `smi_req` pulses for one cycle after any write to command port 0 while `smi_cfg_en` is high. There is no pulse otherwise, and none for a port 1 write.
- R13: Unmapped bus offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable; one counter step per high clock |
| pwr_btn | input | 1 | Power-button event pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_sel | input | 1 | 0 = command byte, 1 = scratch byte |
| cmd_wdata | input | 8 | Command port write data |
| cmd_rdata | output | 8 | Command port read data for `cmd_sel` |
| smi_cfg_en | input | 1 | Allows SMI requests from command writes |
| sci | output | 1 | Level system control interrupt |
| smi_req | output | 1 | One-cycle SMI request |
| poff_req | output | 1 | One-cycle soft power-off request |

## Verification
The bench builds the unit with TMR_W set to 8 rather than the default 24. With that width the counter's top bit rises after 128 ticks and falls at the wrap after 256 ticks. Both overflow edges, and the wrapped read value with its zeroed upper bits, therefore fall within a few hundred cycles instead of millions. Every other register keeps its full 16-bit width, so the bit positions of the events and control fields are the same as in the default build.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int REG_W  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_STS = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_EN  = 6'h02;
  localparam logic [ADDR_W-1:0] OFF_CTL = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_TMR = 6'h08;

  localparam int EV_TMR = 0;
  localparam int EV_GBL = 5;
  localparam int EV_BTN = 8;
  localparam int EV_RTC = 10;
  localparam logic [REG_W-1:0] SCI_MASK =
    (16'd1 << EV_TMR) | (16'd1 << EV_GBL) | (16'd1 << EV_BTN) | (16'd1 << EV_RTC);

  localparam int CTL_SCI_MODE = 0;
  localparam int CTL_SLP_LO   = 10;
  localparam int CTL_STROBE   = 13;

  localparam logic [7:0] CMD_ON  = 8'hF1;
  localparam logic [7:0] CMD_OFF = 8'hF0;

  // level of the interrupt for a given pair of status/enable words
  function automatic logic sci_level(input logic [REG_W-1:0] sts, input logic [REG_W-1:0] en);
    return |(sts & en & SCI_MASK);
  endfunction

  // a write that requests soft power off
  function automatic logic is_poweroff(input logic [REG_W-1:0] v);
    return v[CTL_STROBE] && (v[CTL_SLP_LO+2:CTL_SLP_LO] == 3'd0);
  endfunction
endpackage

// File: rtl/pm_free_counter.sv
module pm_free_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         msb_flip
);
  logic [W-1:0] cnt_nxt;

  function automatic logic [W-1:0] step(input logic [W-1:0] v);
    return v + 1'b1;
  endfunction

  assign cnt_nxt  = step(cnt);
  // top bit changes on this tick, in either direction
  assign msb_flip = tick & (cnt[W-1] ^ cnt_nxt[W-1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt_nxt;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)) else $error("counter moved without tick");
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 1'b1) else $error("counter step wrong");
endmodule

// File: rtl/pm_event_block.sv
module pm_event_block
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_evt,
  input  logic             btn,
  input  logic             sts_wr,
  input  logic             en_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] sts,
  output logic [REG_W-1:0] en,
  output logic             sci
);
  logic [REG_W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    set_vec[EV_TMR] = ovf_evt;
    set_vec[EV_BTN] = btn & en[EV_BTN];
    clr_vec = sts_wr ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
    end else begin
      sts <= (sts & ~clr_vec) | set_vec;
      if (en_wr) en <= wdata;
    end

  assign sci = sci_level(sts, en);

  a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> sts[EV_TMR]) else $error("overflow not recorded");
  a_r5_btn_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (btn && !en[EV_BTN] && !sts[EV_BTN]) |=> !sts[EV_BTN]) else $error("masked button set status");
  a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wdata[EV_BTN] && !btn) |=> !sts[EV_BTN]) else $error("w1c failed");
endmodule

// File: rtl/pm_cmd_port.sv
module pm_cmd_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic       cmd_sel,
  input  logic [7:0] cmd_wdata,
  input  logic       smi_cfg_en,
  output logic [7:0] cmd_rdata,
  output logic       mode_on,
  output logic       mode_off,
  output logic       smi_req
);
  import pm_pkg::*;
  logic [7:0] cmd_q, scratch_q;
  logic       cmd_hit;

  assign cmd_hit  = cmd_wr & ~cmd_sel;
  assign mode_on  = cmd_hit && (cmd_wdata == CMD_ON);
  assign mode_off = cmd_hit && (cmd_wdata == CMD_OFF);
  assign cmd_rdata = cmd_sel ? scratch_q : cmd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_q     <= '0;
      scratch_q <= '0;
      smi_req   <= 1'b0;
    end else begin
      if (cmd_hit) cmd_q <= cmd_wdata;
      if (cmd_wr && cmd_sel) scratch_q <= cmd_wdata;
      smi_req <= cmd_hit & smi_cfg_en;
    end

  a_r12_smi_cause: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> $past(cmd_wr && !cmd_sel && smi_cfg_en)) else $error("spurious smi");
endmodule

// File: rtl/pm_timer_unit.sv
module pm_timer_unit
  import pm_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pwr_btn,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cmd_wr,
  input  logic              cmd_sel,
  input  logic [7:0]        cmd_wdata,
  output logic [7:0]        cmd_rdata,
  input  logic              smi_cfg_en,
  output logic              sci,
  output logic              smi_req,
  output logic              poff_req
);
  logic [TMR_W-1:0] cnt;
  logic             ovf_evt, mode_on, mode_off;
  logic             sts_wr, en_wr, ctl_wr;
  logic [REG_W-1:0] sts, en, ctl_q;

  assign sts_wr = bus_wr && (bus_addr == OFF_STS);
  assign en_wr  = bus_wr && (bus_addr == OFF_EN);
  assign ctl_wr = bus_wr && (bus_addr == OFF_CTL);

  pm_free_counter #(.W(TMR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .msb_flip(ovf_evt));

  pm_event_block u_evt (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .btn(pwr_btn),
    .sts_wr(sts_wr), .en_wr(en_wr), .wdata(bus_wdata),
    .sts(sts), .en(en), .sci(sci));

  pm_cmd_port u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
    .cmd_wdata(cmd_wdata), .smi_cfg_en(smi_cfg_en), .cmd_rdata(cmd_rdata),
    .mode_on(mode_on), .mode_off(mode_off), .smi_req(smi_req));

  // control register: strobe bit never kept, command port overrides bit 0
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_q    <= '0;
      poff_req <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= bus_wdata & ~(16'd1 << CTL_STROBE);
      if (mode_on)       ctl_q[CTL_SCI_MODE] <= 1'b1;
      else if (mode_off) ctl_q[CTL_SCI_MODE] <= 1'b0;
      poff_req <= ctl_wr && is_poweroff(bus_wdata);
    end

  always_comb
    case (bus_addr)
      OFF_STS: bus_rdata = DATA_W'(sts);
      OFF_EN:  bus_rdata = DATA_W'(en);
      OFF_CTL: bus_rdata = DATA_W'(ctl_q);
      OFF_TMR: bus_rdata = DATA_W'(cnt);
      default: bus_rdata = '0;
    endcase

  a_r9_poff_cause: assert property (@(posedge clk) disable iff (!rst_n)
    poff_req |-> $past(ctl_wr && bus_wdata[CTL_STROBE] && bus_wdata[12:10] == 3'd0))
    else $error("spurious power-off");
  a_r10_mode_on: assert property (@(posedge clk) disable iff (!rst_n)
    mode_on |=> ctl_q[CTL_SCI_MODE]) else $error("sci mode not set");
  a_r10_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off |=> !ctl_q[CTL_SCI_MODE]) else $error("sci mode not cleared");
  a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !ctl_q[CTL_STROBE]) else $error("strobe bit stored");
endmodule

// File: tb/sim_pm_timer_unit.sv
module sim_pm_timer_unit;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pwr_btn = 1'b0;
  logic        bus_wr = 1'b0, cmd_wr = 1'b0, cmd_sel = 1'b0, smi_cfg_en = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [7:0]  cmd_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  cmd_rdata;
  logic        sci, smi_req, poff_req;
  logic        poff_s, smi_s;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pm_timer_unit #(.TMR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_btn(pwr_btn),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_wr(cmd_wr), .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .smi_cfg_en(smi_cfg_en), .sci(sci), .smi_req(smi_req), .poff_req(poff_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; poff_s = poff_req;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cwr(input logic s, input logic [7:0] d);
    @(negedge clk); cmd_wr = 1; cmd_sel = s; cmd_wdata = d;
    @(posedge clk); #1; smi_s = smi_req;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick = 0;
  endtask

  task automatic btn_pulse();
    @(negedge clk); pwr_btn = 1;
    @(negedge clk); pwr_btn = 0;
  endtask

  // write offset, write data, read offset, expected read
  localparam logic [5:0]  T_WA[7] = '{6'h02, 6'h04, 6'h04, 6'h08, 6'h00, 6'h0C, 6'h02};
  localparam logic [15:0] T_WD[7] = '{16'h0521, 16'h0401, 16'h2C01, 16'h1234, 16'hFFFF, 16'hBEEF, 16'h0000};
  localparam logic [5:0]  T_RA[7] = '{6'h02, 6'h04, 6'h04, 6'h08, 6'h00, 6'h0C, 6'h02};
  localparam logic [31:0] T_EX[7] = '{32'h0521, 32'h0401, 32'h0C01, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam string       T_RQ[7] = '{"R4", "R8", "R8", "R2", "R6", "R13", "R4"};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // reset state
    rd(6'h08, v); chk("R1 reset timer", v, 0);
    rd(6'h00, v); chk("R4 reset status", v, 0);
    rd(6'h02, v); chk("R4 reset enable", v, 0);
    rd(6'h04, v); chk("R8 reset control", v, 0);
    chk("R7 reset sci", sci, 0);
    chk("R12 reset smi", smi_req, 0);
    chk("R9 reset poff", poff_req, 0);
    // vector table
    for (int i = 0; i < 7; i++) begin
      wr(T_WA[i], T_WD[i]);
      rd(T_RA[i], v);
      chk(T_RQ[i], v, T_EX[i]);
    end
    wr(6'h04, 16'h0000);
    // timer and overflow (TMR_W = 8)
    run_ticks(100); rd(6'h08, v); chk("R1 count 100", v, 100);
    run_ticks(27);  rd(6'h00, v); chk("R3 no flag at 127", v, 0);
    run_ticks(1);   rd(6'h00, v); chk("R3 flag on rise", v, 1);
    chk("R7 masked sci low", sci, 0);
    wr(6'h02, 16'h0001); chk("R7 sci on enable", sci, 1);
    wr(6'h00, 16'h0000); rd(6'h00, v); chk("R6 write zero keeps", v, 1);
    wr(6'h00, 16'h0001); rd(6'h00, v); chk("R6 w1c clears", v, 0);
    chk("R7 sci drops", sci, 0);
    run_ticks(132); rd(6'h08, v); chk("R1 wrap upper zero", v, 4);
    rd(6'h00, v); chk("R3 flag on fall", v, 1);
    repeat (5) @(posedge clk);
    rd(6'h08, v); chk("R2 hold without tick", v, 4);
    wr(6'h00, 16'h0001);
    // power button
    btn_pulse(); rd(6'h00, v); chk("R5 masked button", v, 0);
    wr(6'h02, 16'h0100);
    btn_pulse(); rd(6'h00, v); chk("R5 enabled button", v, 16'h0100);
    chk("R7 sci button", sci, 1);
    wr(6'h00, 16'h0100); chk("R7 sci cleared", sci, 0);
    // power off strobe
    wr(6'h04, 16'h2000); chk("R9 poff pulse", poff_s, 1);
    @(posedge clk); #1; chk("R9 poff one cycle", poff_req, 0);
    rd(6'h04, v); chk("R8 strobe reads zero", v, 0);
    wr(6'h04, 16'h2400); chk("R9 no poff type1", poff_s, 0);
    // command port
    cwr(0, 8'hF1); chk("R12 no smi when off", smi_s, 0);
    rd(6'h04, v); chk("R10 F1 sets mode", v, 32'h0401);
    chk("R10 readback", cmd_rdata, 8'hF1);
    cwr(0, 8'h33); rd(6'h04, v); chk("R10 other keeps", v, 32'h0401);
    cwr(0, 8'hF0); rd(6'h04, v); chk("R10 F0 clears", v, 32'h0400);
    smi_cfg_en = 1;
    cwr(0, 8'hF1); chk("R12 smi pulse", smi_s, 1);
    @(posedge clk); #1; chk("R12 smi one cycle", smi_req, 0);
    cwr(1, 8'h5A); chk("R12 no smi scratch", smi_s, 0);
    @(negedge clk); cmd_sel = 1; #1; chk("R11 scratch read", cmd_rdata, 8'h5A);
    cmd_sel = 0; #1; chk("R11 port0 intact", cmd_rdata, 8'hF1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule